// File: doc/BRIEF.md
# System Clock Source Switch with Bus Prescalers

This block picks the system clock from one of three sources. The sources are an internal RC oscillator, an external oscillator and a PLL. It then derives the clock enables for the main bus, two peripheral buses and the timers on each peripheral bus. Each source is modelled as an enable strobe on one fast reference clock `clk`. The system tick is the strobe of whichever source is active. Every derived enable is a single-cycle pulse of `clk`.

Software writes a requested source. The switch happens only once the requested source reports ready, and `sel_src` always shows the source actually in use. A clock security monitor can be turned on. While the external oscillator is active, the monitor counts reference cycles between its strobes. If the gap reaches a timeout, it declares a failure and returns the system clock to the internal RC source in the same edge. It also raises an interrupt if that interrupt is enabled. The external source stays unselectable until software clears the failure flag. This covers the PLL too, when the PLL is fed from the external oscillator.

The main bus prescaler divides the system tick by a power of two. Each peripheral prescaler divides the main bus enable by a power of two. A timer enable runs at its peripheral bus rate when that prescaler is 1, and at twice that rate otherwise.

Top module: `sysclk_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `sel_src` is 0 (internal RC), `xo_fail`, `fail_irq` and `switch_busy` are 0.
- R2: Source codes are 0 = internal RC, 1 = external oscillator, 2 = PLL. A request for 1 takes effect only while `xo_ready` is 1, and a request for 2 only while `pll_ready` is 1. `sel_src` changes at the first clock edge where the target is ready, and `switch_busy` is 1 while the target differs from `sel_src`.
- R3: Request code 3 is treated as a request for the internal RC source.
- R4: With `css_en` = 1 and `sel_src` = 1, TIMEOUT consecutive reference cycles without `xo_tick` set `xo_fail`, and `sel_src` becomes 0 at the same edge. With `css_en` = 0, no failure is declared.
- R5: While `xo_fail` is 1, a request for source 1, or for source 2 with `pll_from_xo` = 1, selects the internal RC source. A one-cycle `fail_clr` pulse clears the flag, after which the request is honoured.
- R6: `fail_irq` equals `xo_fail` AND `fail_irq_en`.
- R7: `ahb_ce` pulses once every 2^`ahb_sel` system ticks for `ahb_sel` 0..9. Values above 9 divide by 512.
- R8: `apb1_ce` and `apb2_ce` pulse once every 2^sel main bus enables for sel 0..4 (from `apb1_sel` and `apb2_sel`). Values above 4 divide by 16.
- R9: `tim1_ce` and `tim2_ce` equal their bus enable when that bus prescaler is 1. Otherwise they pulse twice per bus enable period, and every bus enable carries a timer enable.
- R10: The system tick is the strobe of the active source. With `ahb_sel` = 0, `ahb_ce` follows that strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low reset |
| rc_tick | input | 1 | Internal RC source strobe |
| xo_tick | input | 1 | External oscillator strobe |
| pll_tick | input | 1 | PLL output strobe |
| xo_ready | input | 1 | External oscillator ready |
| pll_ready | input | 1 | PLL ready |
| pll_from_xo | input | 1 | PLL input is the external oscillator (else RC/2) |
| src_req | input | 2 | Requested system clock source |
| css_en | input | 1 | Clock security monitor enable |
| fail_irq_en | input | 1 | Failure interrupt enable |
| fail_clr | input | 1 | Clears the failure flag |
| ahb_sel | input | AHB_SW (4) | Main bus divide exponent |
| apb1_sel | input | APB_SW (3) | Low-speed peripheral bus divide exponent |
| apb2_sel | input | APB_SW (3) | High-speed peripheral bus divide exponent |
| sel_src | output | 2 | Source in use |
| switch_busy | output | 1 | Requested switch still pending |
| xo_fail | output | 1 | External oscillator failure flag |
| fail_irq | output | 1 | Failure interrupt |
| ahb_ce | output | 1 | Main bus clock enable |
| apb1_ce | output | 1 | Low-speed bus clock enable |
| apb2_ce | output | 1 | High-speed bus clock enable |
| tim1_ce | output | 1 | Timer enable on the low-speed bus |
| tim2_ce | output | 1 | Timer enable on the high-speed bus |

## Verification
Two things can fall in the same cycle. The first is a timeout detection. The second is a pending switch request or a `fail_clr` pulse. The bench keeps requesting the external source while its strobes stop. It then checks that the failure wins: `sel_src` returns to 0 and stays there while `xo_fail` holds, even with `xo_ready` high and the strobes restarted. Only after the clear pulse may the request take effect. Bus and timer enables are judged by counting pulses over whole periods, against counts computed from the divide exponents.

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl #(
  parameter int TIMEOUT     = 16,
  parameter int AHB_LOG_MAX = 9,
  parameter int APB_LOG_MAX = 4,
  parameter int AHB_SW      = $clog2(AHB_LOG_MAX + 1),
  parameter int APB_SW      = $clog2(APB_LOG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rc_tick,
  input  logic              xo_tick,
  input  logic              pll_tick,
  input  logic              xo_ready,
  input  logic              pll_ready,
  input  logic              pll_from_xo,
  input  logic [1:0]        src_req,
  input  logic              css_en,
  input  logic              fail_irq_en,
  input  logic              fail_clr,
  input  logic [AHB_SW-1:0] ahb_sel,
  input  logic [APB_SW-1:0] apb1_sel,
  input  logic [APB_SW-1:0] apb2_sel,
  output logic [1:0]        sel_src,
  output logic              switch_busy,
  output logic              xo_fail,
  output logic              fail_irq,
  output logic              ahb_ce,
  output logic              apb1_ce,
  output logic              apb2_ce,
  output logic              tim1_ce,
  output logic              tim2_ce
);
  localparam logic [1:0] SRC_RC = 2'd0, SRC_XO = 2'd1, SRC_PLL = 2'd2;
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam int AW = (AHB_LOG_MAX > 0) ? AHB_LOG_MAX : 1;
  localparam int PW = (APB_LOG_MAX > 0) ? APB_LOG_MAX : 1;
  localparam logic [CW-1:0] CNT_END = CW'(TIMEOUT - 1);

  logic [1:0]    active, target;
  logic          fail_q, target_ok, monitor, detect, sys_tick;
  logic [CW-1:0] mon_cnt;

  always_comb begin
    case (src_req)
      SRC_XO:  target = fail_q ? SRC_RC : SRC_XO;
      SRC_PLL: target = (fail_q && pll_from_xo) ? SRC_RC : SRC_PLL;
      default: target = SRC_RC;
    endcase
  end

  assign target_ok = (target == SRC_RC) || (target == SRC_XO && xo_ready) ||
                     (target == SRC_PLL && pll_ready);
  assign monitor   = css_en && (active == SRC_XO);
  assign detect    = monitor && !xo_tick && (mon_cnt == CNT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= SRC_RC;
      fail_q  <= 1'b0;
      mon_cnt <= '0;
    end else begin
      if (detect) active <= SRC_RC;
      else if (target != active && target_ok) active <= target;
      if (detect) fail_q <= 1'b1;
      else if (fail_clr) fail_q <= 1'b0;
      if (!monitor || xo_tick) mon_cnt <= '0;
      else if (mon_cnt != CNT_END) mon_cnt <= mon_cnt + 1'b1;
    end
  end

  always_comb begin
    case (active)
      SRC_XO:  sys_tick = xo_tick;
      SRC_PLL: sys_tick = pll_tick;
      default: sys_tick = rc_tick;
    endcase
  end

  assign sel_src     = active;
  assign switch_busy = (target != active);
  assign xo_fail     = fail_q;
  assign fail_irq    = fail_q && fail_irq_en;

  logic [AHB_SW-1:0] ahb_log;
  logic [AW-1:0]     ahb_lim, ahb_cnt;
  assign ahb_log = (ahb_sel > AHB_SW'(AHB_LOG_MAX)) ? AHB_SW'(AHB_LOG_MAX) : ahb_sel;
  assign ahb_lim = AW'((32'd1 << ahb_log) - 32'd1);
  assign ahb_ce  = sys_tick && (ahb_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ahb_cnt <= '0;
    else if (sys_tick) ahb_cnt <= (ahb_cnt == '0 || ahb_cnt > ahb_lim) ? ahb_lim : ahb_cnt - 1'b1;
  end

  logic [APB_SW-1:0] psel [2];
  logic [1:0]        pce, tce;
  assign psel[0] = apb1_sel;
  assign psel[1] = apb2_sel;

  for (genvar g = 0; g < 2; g++) begin : g_apb
    logic [APB_SW-1:0] plog;
    logic [PW-1:0]     lim, cnt;
    assign plog   = (psel[g] > APB_SW'(APB_LOG_MAX)) ? APB_SW'(APB_LOG_MAX) : psel[g];
    assign lim    = PW'((32'd1 << plog) - 32'd1);
    assign pce[g] = ahb_ce && (cnt == '0);
    assign tce[g] = (plog == '0) ? pce[g]
                  : ahb_ce && (cnt == '0 || cnt == (lim >> 1) + 1'b1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (ahb_ce) cnt <= (cnt == '0 || cnt > lim) ? lim : cnt - 1'b1;
    end
  end

  assign apb1_ce = pce[0];
  assign apb2_ce = pce[1];
  assign tim1_ce = tce[0];
  assign tim2_ce = tce[1];

  a_r1_reset_rc: assert property (@(posedge clk) !rst_n |=> (sel_src == SRC_RC && !xo_fail));
  a_r2_switch_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_src == SRC_XO && $past(sel_src) != SRC_XO) |-> $past(xo_ready));
  a_r4_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xo_fail) |-> sel_src == SRC_RC);
  a_r5_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (xo_fail && $past(xo_fail)) |-> sel_src != SRC_XO);
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    fail_irq |-> xo_fail);
  a_r8_apb_in_ahb: assert property (@(posedge clk) disable iff (!rst_n)
    (apb1_ce || apb2_ce) |-> ahb_ce);
  a_r9_tim_covers_apb: assert property (@(posedge clk) disable iff (!rst_n)
    (apb1_ce |-> tim1_ce) and (apb2_ce |-> tim2_ce));
  a_r10_ahb_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ahb_ce |-> (rc_tick || xo_tick || pll_tick));
endmodule

// File: tb/sysclk_ctrl_test.sv
module sysclk_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic rc_tick = 1, xo_tick = 0, pll_tick = 1, xo_ready = 0, pll_ready = 0, pll_from_xo = 0;
  logic [1:0] src_req = 0;
  logic css_en = 0, fail_irq_en = 0, fail_clr = 0;
  logic [3:0] ahb_sel = 0;
  logic [2:0] apb1_sel = 0, apb2_sel = 0;
  logic [1:0] sel_src;
  logic switch_busy, xo_fail, fail_irq, ahb_ce, apb1_ce, apb2_ce, tim1_ce, tim2_ce;
  int checks = 0, fails = 0, cyc = 0;
  logic xo_run = 0;
  int ph = 0;

  sysclk_ctrl uut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    #1;
    if (xo_run) begin xo_tick = (ph == 0); ph = (ph + 1) % 4; end
    else xo_tick = 0;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic int pw2(int e, int mx);
    return 1 << ((e > mx) ? mx : e);
  endfunction

  task automatic count(int n, output int a, output int p1, output int p2,
                       output int t1, output int t2);
    a = 0; p1 = 0; p2 = 0; t1 = 0; t2 = 0;
    repeat (n) begin
      @(posedge clk); #2;
      a += int'(ahb_ce); p1 += int'(apb1_ce); p2 += int'(apb2_ce);
      t1 += int'(tim1_ce); t2 += int'(tim2_ce);
    end
  endtask

  task automatic rate_case(int ah, int b1, int b2);
    int a, p1, p2, t1, t2, pa, q1, q2, mx, w;
    ahb_sel = 4'(ah); apb1_sel = 3'(b1); apb2_sel = 3'(b2);
    pa = pw2(ah, 9); q1 = pa * pw2(b1, 4); q2 = pa * pw2(b2, 4);
    mx = (q1 > q2) ? q1 : q2;
    step(2 * mx + 1030);
    w = 4 * mx;
    count(w, a, p1, p2, t1, t2);
    chk("R7 ahb rate", a, w / pa);
    chk("R8 apb1 rate", p1, w / q1);
    chk("R8 apb2 rate", p2, w / q2);
    chk("R9 tim1 rate", t1, (pw2(b1, 4) == 1) ? w / q1 : 2 * w / q1);
    chk("R9 tim2 rate", t2, (pw2(b2, 4) == 1) ? w / q2 : 2 * w / q2);
  endtask

  initial begin
    int bad;
    void'($urandom(32'd7));
    step(3);
    chk("R1 reset sel", sel_src, 0);
    chk("R1 reset fail", xo_fail, 0);
    chk("R1 reset busy", switch_busy, 0);
    rst_n = 1;
    step(2);
    chk("R1 after reset sel", sel_src, 0);
    chk("R1 after reset irq", fail_irq, 0);

    // R10: system tick follows the RC strobe
    bad = 0;
    repeat (60) begin
      @(posedge clk); #1 rc_tick = 1'($urandom); #1;
      if (ahb_ce != rc_tick) bad++;
    end
    rc_tick = 1;
    chk("R10 ahb_ce follows rc strobe", bad, 0);

    // R7 R8 R9: directed and random prescaler settings
    rate_case(0, 0, 1);
    rate_case(12, 0, 0);
    rate_case(1, 7, 2);
    for (int i = 0; i < 10; i++) rate_case(int'($urandom % 4), int'($urandom % 6), int'($urandom % 6));
    ahb_sel = 0; apb1_sel = 0; apb2_sel = 0;

    // R2: switch waits for readiness
    xo_run = 1;
    src_req = 2'd1;
    step(4);
    chk("R2 not ready stays rc", sel_src, 0);
    chk("R2 busy while pending", switch_busy, 1);
    xo_ready = 1;
    step(2);
    chk("R2 switched to xo", sel_src, 1);
    chk("R2 busy cleared", switch_busy, 0);

    // R10: tick follows the external strobe
    bad = 0;
    repeat (40) begin @(posedge clk); #2; if (ahb_ce != xo_tick) bad++; end
    chk("R10 ahb_ce follows xo strobe", bad, 0);

    // R3: code 3 means RC
    src_req = 2'd3;
    step(2);
    chk("R3 reserved code selects rc", sel_src, 0);
    src_req = 2'd1;
    step(2);

    // R4: monitor off - no failure
    xo_run = 0;
    step(40);
    chk("R4 no detect when disabled", xo_fail, 0);
    chk("R4 stays xo when disabled", sel_src, 1);

    // R4 R5 R6: failure with a pending xo request
    xo_run = 1; css_en = 1; fail_irq_en = 1;
    step(20);
    chk("R4 healthy xo no fail", xo_fail, 0);
    xo_run = 0;
    step(8);
    chk("R4 before timeout", xo_fail, 0);
    step(20);
    chk("R4 fail detected", xo_fail, 1);
    chk("R4 fallback to rc", sel_src, 0);
    chk("R6 irq raised", fail_irq, 1);
    fail_irq_en = 0;
    step(1);
    chk("R6 irq masked", fail_irq, 0);
    xo_run = 1;
    step(10);
    chk("R5 xo blocked while failed", sel_src, 0);
    pll_ready = 1; pll_from_xo = 1; src_req = 2'd2;
    step(3);
    chk("R5 pll from xo blocked", sel_src, 0);
    pll_from_xo = 0;
    step(2);
    chk("R5 pll from rc allowed", sel_src, 2);
    src_req = 2'd1;
    step(2);
    chk("R5 still rc after pll", sel_src, 0);
    @(posedge clk); #1 fail_clr = 1;
    @(posedge clk); #1 fail_clr = 0;
    step(2);
    chk("R5 fail cleared", xo_fail, 0);
    chk("R5 xo honoured after clear", sel_src, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule